// File: doc/BRIEF.md
# Four-Channel Fan PWM Generator

This block drives up to four fan-speed PWM pins from a small register file. Each channel counts down from a programmable reload value to zero, one step per channel tick. Its pin is high while the count is at or below a comparator value, and an optional polarity flip is applied last. The tick rate comes from two stages. The first is an 8-bit prescaler, and each prescaler is shared by a pair of neighbouring channels. The second is a per-channel power-of-two divider picked by a 4-bit select field.

Software holds a channel at a fixed level, for example for a zero duty request, by clearing the channel's run bit. The pin then sits at the level of the channel's invert bit. A channel either reloads at the end of every period or runs once and parks at zero. A new comparator value is held in a shadow register until the next period boundary, so a duty change never produces a shortened pulse.

Top module: `pwm_fan_ctrl`

## Requirements
- R1: After reset all pins are low; prescale reads 0, clock select reads 0x00004444, control reads 0x00088808 (only the auto-reload bits set), every reload register reads 255 and every comparator reads 0.
- R2: Register offsets: prescale at 0x00, clock select at 0x04, control at 0x08; channel c has its reload at 0x0C+12c, its comparator at 0x10+12c and a read-only live count at 0x14+12c.
- R3: In the control register, channel c has its run bit at position 0 for c=0 and 4+4c otherwise (0, 8, 12, 16), its invert bit two places above and its auto-reload bit three places above.
- R4: Prescale bits 7:0 pace channels 0 and 1, bits 15:8 pace channels 2 and 3; a prescaler field f gives one tick every f+1 clocks.
- R5: Channel c's clock-select nibble at bits 4c+3:4c with value v in 0..3 further divides its tick by 2^(v+1); values 4..15 leave it undivided.
- R6: In auto-reload mode the period is reload+1 channel ticks, and the non-inverted pin is high for min(comparator, reload)+1 of them.
- R7: When the invert bit is set, the pin is the complement of the non-inverted waveform.
- R8: While the run bit is clear, the count is held at the reload value and the pin stays constantly at the invert bit's level, so a cleared run bit with invert set gives a steady high.
- R9: With the auto-reload bit clear, the channel counts down once and parks at 0, holding the pin at its active level; clearing and setting the run bit re-arms it from the reload value.
- R10: A comparator write takes effect only at the next period boundary, or at once while the channel is stopped.
- R11: The live count register returns the channel's current count value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte offset for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 4 | PWM pins, one per channel, registered |

## Verification
The bench goes after the sharing of a prescaler by two channels. A design that decoded the wrong byte of the prescale register would stretch or shrink the wrong channel's period, and the measured high time over two periods would miss its expected value. It also checks that a comparator write in mid-period cannot shorten the running pulse: a design that loaded it at once would drive the pin high early, which is caught one cycle after the write settles. Further tests cover a comparator above the reload value, which must hold the pin high for the whole period; a one-shot channel, which must park high instead of wrapping; and a stopped channel with invert set, which must sit high with no toggling. A wrong control bit position shows up as a neighbouring channel moving instead.

// File: rtl/pwm_fan_pkg.sv
package pwm_fan_pkg;

  localparam int REG_W   = 32;
  localparam int SEL_W   = 4;
  localparam logic [SEL_W-1:0] SEL_RST = 4'h4;

  localparam int OFS_PRE = 'h00;
  localparam int OFS_SEL = 'h04;
  localparam int OFS_CTL = 'h08;
  localparam int CH_BASE = 'h0C;
  localparam int CH_STEP = 12;

  // slot 0 = reload, 1 = comparator, 2 = live count
  function automatic int chan_ofs(input int ch, input int slot);
    return CH_BASE + CH_STEP * ch + 4 * slot;
  endfunction

  function automatic int ctl_run_pos(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int ctl_inv_pos(input int ch);
    return ctl_run_pos(ch) + 2;
  endfunction

  function automatic int ctl_arl_pos(input int ch);
    return ctl_run_pos(ch) + 3;
  endfunction

  function automatic logic [REG_W-1:0] ctl_mask(input int nch);
    logic [REG_W-1:0] v;
    v = '0;
    for (int c = 0; c < nch; c++) begin
      v[ctl_run_pos(c)] = 1'b1;
      v[ctl_inv_pos(c)] = 1'b1;
      v[ctl_arl_pos(c)] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [REG_W-1:0] ctl_reset_val(input int nch);
    logic [REG_W-1:0] v;
    v = '0;
    for (int c = 0; c < nch; c++) v[ctl_arl_pos(c)] = 1'b1;
    return v;
  endfunction

  // select value -> extra divide ratio (2,4,8,16 or 1)
  function automatic logic [4:0] sel_to_div(input logic [SEL_W-1:0] s);
    if (s < SEL_W'(4)) return 5'(5'd2 << s);
    return 5'd1;
  endfunction

  // non-inverted level: active while the count is at or below the threshold
  function automatic logic duty_level(input logic [15:0] cnt, input logic [15:0] thr);
    return cnt <= thr;
  endfunction

endpackage

// File: rtl/pwm_fan_regs.sv
module pwm_fan_regs
  import pwm_fan_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NPAIR = 2,
  parameter int CNT_W = 8,
  parameter int PRE_W = 8,
  parameter int AW    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [AW-1:0]                   bus_addr,
  input  logic [REG_W-1:0]                bus_wdata,
  output logic [REG_W-1:0]                bus_rdata,
  input  logic [NCH-1:0][CNT_W-1:0]       cnt_now,
  output logic [NPAIR-1:0][PRE_W-1:0]     pre_div,
  output logic [NCH-1:0][SEL_W-1:0]       sel,
  output logic [NCH-1:0]                  run,
  output logic [NCH-1:0]                  inv,
  output logic [NCH-1:0]                  arl,
  output logic [NCH-1:0][CNT_W-1:0]       reload,
  output logic [NCH-1:0][CNT_W-1:0]       cmp
);

  localparam logic [REG_W-1:0] CTL_MASK = ctl_mask(NCH);
  localparam logic [REG_W-1:0] CTL_RST  = ctl_reset_val(NCH);

  logic [NPAIR-1:0][PRE_W-1:0] pre_q;
  logic [NCH-1:0][SEL_W-1:0]   sel_q;
  logic [REG_W-1:0]            ctl_q;
  logic [NCH-1:0][CNT_W-1:0]   reload_q;
  logic [NCH-1:0][CNT_W-1:0]   cmp_q;

  logic wr_pre, wr_sel, wr_ctl;
  assign wr_pre = bus_wr && (bus_addr == AW'(OFS_PRE));
  assign wr_sel = bus_wr && (bus_addr == AW'(OFS_SEL));
  assign wr_ctl = bus_wr && (bus_addr == AW'(OFS_CTL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      sel_q    <= {NCH{SEL_RST}};
      ctl_q    <= CTL_RST;
      reload_q <= '1;
      cmp_q    <= '0;
    end else begin
      if (wr_pre) pre_q <= bus_wdata[NPAIR*PRE_W-1:0];
      if (wr_sel) sel_q <= bus_wdata[NCH*SEL_W-1:0];
      if (wr_ctl) ctl_q <= bus_wdata & CTL_MASK;
      for (int c = 0; c < NCH; c++) begin
        if (bus_wr && (bus_addr == AW'(chan_ofs(c, 0)))) reload_q[c] <= bus_wdata[CNT_W-1:0];
        if (bus_wr && (bus_addr == AW'(chan_ofs(c, 1)))) cmp_q[c]    <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ctl
    assign run[c] = ctl_q[ctl_run_pos(c)];
    assign inv[c] = ctl_q[ctl_inv_pos(c)];
    assign arl[c] = ctl_q[ctl_arl_pos(c)];
  end

  assign pre_div = pre_q;
  assign sel     = sel_q;
  assign reload  = reload_q;
  assign cmp     = cmp_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_PRE)) bus_rdata = REG_W'(pre_q);
    if (bus_addr == AW'(OFS_SEL)) bus_rdata = REG_W'(sel_q);
    if (bus_addr == AW'(OFS_CTL)) bus_rdata = ctl_q;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == AW'(chan_ofs(c, 0))) bus_rdata = REG_W'(reload_q[c]);
      if (bus_addr == AW'(chan_ofs(c, 1))) bus_rdata = REG_W'(cmp_q[c]);
      if (bus_addr == AW'(chan_ofs(c, 2))) bus_rdata = REG_W'(cnt_now[c]);
    end
  end

endmodule

// File: rtl/pwm_fan_prescale.sv
module pwm_fan_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] div_m1,
  output logic             tick
);

  logic [PRE_W-1:0] cnt_q;

  // >= rather than == so a smaller field written mid-count recovers at once
  assign tick = (cnt_q >= div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/pwm_fan_chan.sv
module pwm_fan_chan
  import pwm_fan_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  input  logic             inv,
  input  logic             arl,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp_new,
  output logic             ch_tick,
  output logic             boundary,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_act,
  output logic             pwm
);

  logic [4:0]       div_n;
  logic [4:0]       div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic             pwm_q;
  logic             at_zero;

  assign div_n    = sel_to_div(sel);
  assign ch_tick  = pre_tick && (div_q >= div_n - 5'd1);
  assign at_zero  = (cnt_q == '0);
  assign boundary = run && ch_tick && at_zero && arl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (pre_tick) div_q <= ch_tick ? 5'd0 : div_q + 5'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      cmp_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (!run) begin
        cnt_q <= reload;
        cmp_q <= cmp_new;
      end else if (ch_tick) begin
        if (at_zero) begin
          if (arl) begin
            cnt_q <= reload;
            cmp_q <= cmp_new;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      pwm_q <= (run && duty_level(16'(cnt_q), 16'(cmp_q))) ^ inv;
    end
  end

  assign cnt     = cnt_q;
  assign cmp_act = cmp_q;
  assign pwm     = pwm_q;

endmodule

// File: rtl/pwm_fan_ctrl.sv
module pwm_fan_ctrl
  import pwm_fan_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CH_PER_PRE = 2,
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 8,
  parameter int AW         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NCH-1:0]   pwm_o
);

  localparam int NPAIR = (NCH + CH_PER_PRE - 1) / CH_PER_PRE;

  logic [NPAIR-1:0][PRE_W-1:0] pre_div;
  logic [NPAIR-1:0]            pre_tick;
  logic [NCH-1:0][SEL_W-1:0]   sel_v;
  logic [NCH-1:0]              run_v, inv_v, arl_v;
  logic [NCH-1:0][CNT_W-1:0]   reload_v, cmp_v, cnt_v, cmp_act_v;
  logic [NCH-1:0]              ch_tick_v, boundary_v;

  pwm_fan_regs #(
    .NCH(NCH), .NPAIR(NPAIR), .CNT_W(CNT_W), .PRE_W(PRE_W), .AW(AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_now(cnt_v), .pre_div(pre_div), .sel(sel_v),
    .run(run_v), .inv(inv_v), .arl(arl_v),
    .reload(reload_v), .cmp(cmp_v)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pre
    pwm_fan_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .div_m1(pre_div[p]), .tick(pre_tick[p])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_fan_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .pre_tick(pre_tick[c / CH_PER_PRE]),
      .sel(sel_v[c]), .run(run_v[c]), .inv(inv_v[c]), .arl(arl_v[c]),
      .reload(reload_v[c]), .cmp_new(cmp_v[c]),
      .ch_tick(ch_tick_v[c]), .boundary(boundary_v[c]),
      .cnt(cnt_v[c]), .cmp_act(cmp_act_v[c]), .pwm(pwm_o[c])
    );
  end

endmodule

// File: rtl/pwm_fan_ctrl_chk.sv
module pwm_fan_ctrl_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            run,
  input logic [NCH-1:0]            inv,
  input logic [NCH-1:0]            arl,
  input logic [NCH-1:0]            ch_tick,
  input logic [NCH-1:0]            boundary,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0][CNT_W-1:0] cmp_act,
  input logic [NCH-1:0][CNT_W-1:0] reload,
  input logic [NCH-1:0]            pwm_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_a
    assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      run[c] && !ch_tick[c] |=> $stable(cnt[c]));

    assert_reload_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      boundary[c] |=> cnt[c] == $past(reload[c]));

    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] |=> pwm_o[c] == $past(inv[c]));

    assert_oneshot_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run[c] && !arl[c] && cnt[c] == '0 |=> cnt[c] == '0);

    assert_cmp_only_at_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      run[c] && !boundary[c] |=> $stable(cmp_act[c]));
  end

endmodule

bind pwm_fan_ctrl pwm_fan_ctrl_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .run(run_v), .inv(inv_v), .arl(arl_v),
  .ch_tick(ch_tick_v), .boundary(boundary_v),
  .cnt(cnt_v), .cmp_act(cmp_act_v), .reload(reload_v),
  .pwm_o(pwm_o)
);

// File: tb/sim_pwm_fan_ctrl.sv
module sim_pwm_fan_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  logic [31:0] ctl_sh = 32'h0008_8808;
  logic [31:0] sel_sh = 32'h0000_4444;
  logic [31:0] pre_sh = 32'h0;

  always #2 clk = ~clk;

  pwm_fan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  // fields: ch, prescale, select, reload, comparator, invert, window, expected high cycles
  localparam int NVEC = 8;
  localparam int VEC [NVEC][8] = '{
    '{0, 0, 4, 255, 127, 0, 512, 256},
    '{1, 0, 4,   9,   2, 0,  20,   6},
    '{2, 2, 4,  15,   3, 1,  96,  72},
    '{3, 0, 1,   7,   0, 0,  64,   8},
    '{0, 1, 0,   4,   4, 0,  40,  40},
    '{1, 1, 2,   3,   1, 1, 128,  64},
    '{3, 0, 3,   1,   0, 0,  64,  32},
    '{2, 0, 5,   5, 200, 0,  12,  12}
  };

  function automatic int run_pos(input int ch);
    case (ch)
      0: return 0;
      1: return 8;
      2: return 12;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic meas(input int ch, input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_o[ch]) h++;
    end
  endtask

  task automatic cfg(input int ch, input int pre, input int sel, input int rl,
                     input int cm, input int iv, input int ar);
    ctl_sh[run_pos(ch)]     = 1'b0;
    ctl_sh[run_pos(ch) + 2] = iv[0];
    ctl_sh[run_pos(ch) + 3] = ar[0];
    wr(8'h08, ctl_sh);
    pre_sh[8*(ch/2) +: 8] = pre[7:0];
    wr(8'h00, pre_sh);
    sel_sh[4*ch +: 4] = sel[3:0];
    wr(8'h04, sel_sh);
    wr(8'(12 + 12*ch), 32'(rl));
    wr(8'(16 + 12*ch), 32'(cm));
  endtask

  task automatic set_run(input int ch, input bit v);
    ctl_sh[run_pos(ch)] = v;
    wr(8'h08, ctl_sh);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R6: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pins low", pwm_o, 0);
    rd(8'h00, d); chk("R1 prescale", d, 0);
    rd(8'h04, d); chk("R1 clock select", d, 32'h4444);
    rd(8'h08, d); chk("R1 control", d, 32'h0008_8808);
    rd(8'h0C, d); chk("R1 reload ch0", d, 255);
    rd(8'h34, d); chk("R1 comparator ch3", d, 0);
    rd(8'h14, d); chk("R11 count held at reload while stopped", d, 255);

    // R8 R3: stopped channel 1 with invert set sits high, others untouched
    ctl_sh[10] = 1'b1;
    wr(8'h08, ctl_sh);
    repeat (2) @(negedge clk);
    meas(1, 50, h);
    chk("R8 R3 stopped+invert steady high", h, 50);
    chk("R3 neighbour pins unchanged", {pwm_o[3:2], pwm_o[0]}, 0);
    ctl_sh[10] = 1'b0;
    wr(8'h08, ctl_sh);

    // R4 R5 R6 R7 vector table
    for (int i = 0; i < NVEC; i++) begin
      int ch;
      ch = VEC[i][0];
      cfg(ch, VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], 1);
      set_run(ch, 1'b1);
      repeat (VEC[i][6] + 20) @(negedge clk);
      meas(ch, VEC[i][6], h);
      chk($sformatf("R4 R5 R6 R7 vector %0d high cycles", i), h, VEC[i][7]);
      set_run(ch, 1'b0);
    end

    // R2 offsets of the upper channels
    rd(8'h30, d); chk("R2 ch3 reload offset", d, 1);
    rd(8'h34, d); chk("R2 ch3 comparator offset", d, 0);
    rd(8'h28, d); chk("R2 ch2 comparator offset", d, 200);

    // R10 comparator change waits for the period boundary
    cfg(0, 0, 4, 255, 10, 0, 1);
    set_run(0, 1'b1);
    repeat (20) @(negedge clk);
    wr(8'h10, 32'd250);
    repeat (3) @(negedge clk);
    chk("R10 no early pulse after mid-period write", pwm_o[0], 0);
    repeat (300) @(negedge clk);
    meas(0, 256, h);
    chk("R10 new duty after boundary", h, 251);
    set_run(0, 1'b0);

    // R9 one-shot
    cfg(1, 0, 4, 9, 3, 0, 0);
    set_run(1, 1'b1);
    repeat (2) @(negedge clk);
    chk("R9 one-shot starts low", pwm_o[1], 0);
    repeat (40) @(negedge clk);
    meas(1, 100, h);
    chk("R9 one-shot parks high", h, 100);
    rd(8'h20, d); chk("R11 parked count reads zero", d, 0);
    set_run(1, 1'b0);
    set_run(1, 1'b1);
    repeat (2) @(negedge clk);
    chk("R9 re-armed one-shot low again", pwm_o[1], 0);
    set_run(1, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule